// File: doc/BRIEF.md
# Acknowledge-Released Receive Queue

This block is a circular receive queue for fixed-width frame records. Its backing array holds up to 64 elements, and the active size is set at run time. A writer pushes accepted frames, one per cycle. A reader always sees the record at the get index. To release a record, the reader writes its index to the acknowledge port. That one write frees the named element and every older element still in the queue.

Status outputs give the fill level, the get index, the put index, a full flag and a message-lost flag. Four sticky interrupt flags report these events:

| Bit | Event |
|-----|-------|
| 0 | a record was stored |
| 1 | the fill level reached the watermark |
| 2 | the queue became full |
| 3 | a record was lost |

Each flag is cleared by writing 1 to it. When the queue is full, a mode input picks what an incoming write does. In blocking mode the new write is dropped. In overwrite mode the new write replaces the oldest record.

The control is a four-state machine:

| State | Meaning |
|-------|---------|
| `Q_OFF` | size 0; the queue is disabled |
| `Q_EMPTY` | no records held |
| `Q_PARTIAL` | some records held, not full |
| `Q_FULL` | fill level equals the size |

The named transitions are:
- *enable*: `Q_OFF` to `Q_EMPTY`.
- *first-store*: `Q_EMPTY` to `Q_PARTIAL`.
- *single-fill*: `Q_EMPTY` to `Q_FULL`, when the size is 1.
- *top-up*: `Q_PARTIAL` to `Q_FULL`.
- *release*: `Q_FULL` to `Q_PARTIAL` or `Q_EMPTY`.
- *drain*: `Q_PARTIAL` to `Q_EMPTY`.
- *disable*: any state to `Q_OFF`.

To change the size, pass through size 0 first.

Top module: `rx_ack_queue`

## Requirements
- R1: After reset, fill level, get index, put index, full, message-lost and all four interrupt flags are 0.
- R2: The effective size is the 7-bit size input, limited to 64. A size of 0 holds the fill level and both indices at 0 and clears message-lost. While the size is 0, writes and acknowledges are ignored and raise no flag.
- R3: A stored write places its record at the put index. The put index then advances by one, wrapping at the size, and the fill level rises by one. `rd_data` shows the record at the get index while the fill level is nonzero.
- R4: An acknowledge of index k is accepted only when both of these hold:
  - k is below the size.
  - d = (k - get) mod size is below the fill level.

  When accepted, the get index becomes (k+1) mod size and the fill level drops by d+1. Any other acknowledge changes nothing.
- R5: When an acknowledge and a write arrive in the same cycle, the acknowledge is applied first. The write then sees the freed space.
- R6: In blocking mode (mode input 0), a write to a full queue is dropped and leaves the put index and fill level unchanged. It sets the message-lost status and interrupt bit 3.
- R7: In overwrite mode (mode input 1), a write to a full queue overwrites the oldest record. The put index and the get index each advance by one. The fill level stays at the size, and nothing is flagged as lost.
- R8: Message-lost status stays set until the next accepted acknowledge clears it. If a drop happens in that same cycle, the drop wins.
- R9: `full` is high exactly when the fill level equals a nonzero size. Interrupt bit 2 is set when the fill level enters the size from below.
- R10: Interrupt bit 1 is set when the fill level goes from below the watermark to at or above it. A watermark of 0, or one above the size, never sets bit 1.
- R11: Interrupt bit 0 is set on every stored write, including an overwrite.
- R12: Interrupt flags are sticky and clear when 1 is written to their bit of `irq_clr`. If a flag is set and cleared in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_size | input | 7 | Queue size; 0 disables the queue |
| cfg_wmark | input | 7 | Watermark fill level |
| cfg_ovwr | input | 1 | Full behaviour: 0 blocking, 1 overwrite |
| wr_valid | input | 1 | Push a record |
| wr_data | input | REC_W | Record to push |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_idx | input | 6 | Index of the last element being released |
| irq_clr | input | 4 | Write-1-to-clear for the interrupt flags |
| rd_data | output | REC_W | Record at the get index |
| fill_lvl | output | 7 | Number of records held |
| get_idx | output | 6 | Oldest record index |
| put_idx | output | 6 | Next write index |
| full | output | 1 | Queue full |
| msg_lost | output | 1 | A record was dropped since the last release |
| irq | output | 4 | Interrupt flags: new, watermark, full, lost |

## Verification
The assertions check several rules on every cycle:
- the disabled state stays at zero;
- in blocking mode a full queue keeps its put index and fill level, and raises the lost flag;
- in overwrite mode the queue stays full;
- an idle cycle moves nothing;
- a new-message flag follows every write that has room;
- a watermark flag does not come back after a clear when no write follows.

Other behaviours depend on values carried across many cycles, so only the bench scenarios show them. These are:
- the modular release distance of an acknowledge;
- rejection of stale or out-of-range acknowledges;
- the ordering when an acknowledge and a write share a cycle;
- which record an overwrite displaces;
- the watermark crossing;
- wraparound at a full 64-element size.

The bench covers these with a behavioural reference model that is compared on every clock.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    typedef enum logic [1:0] {
        Q_OFF,
        Q_EMPTY,
        Q_PARTIAL,
        Q_FULL
    } qstate_e;

    localparam int IRQ_NEW   = 0;
    localparam int IRQ_WMARK = 1;
    localparam int IRQ_FULL  = 2;
    localparam int IRQ_LOST  = 3;
    localparam int IRQ_N     = 4;
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int DEPTH = 64,
    parameter int REC_W = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [REC_W-1:0] wdata,
    input  logic [IDX_W-1:0] raddr,
    output logic [REC_W-1:0] rdata
);
    logic [REC_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
    import rxq_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cfg_size,
    input  logic [CNT_W-1:0] cfg_wmark,
    input  logic             cfg_ovwr,
    input  logic             wr_valid,
    input  logic             ack_valid,
    input  logic [IDX_W-1:0] ack_idx,
    output logic             store,
    output logic [IDX_W-1:0] put_q,
    output logic [IDX_W-1:0] get_q,
    output logic [CNT_W-1:0] fill_q,
    output logic             lost_q,
    output logic             full_o,
    output logic [IRQ_N-1:0] events
);
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] ONE_C   = CNT_W'(1);

    function automatic logic [IDX_W-1:0] wrap_inc(input logic [IDX_W-1:0] p,
                                                  input logic [CNT_W-1:0] sz);
        logic [CNT_W-1:0] t;
        t = {1'b0, p} + ONE_C;
        return (t >= sz) ? '0 : t[IDX_W-1:0];
    endfunction

    qstate_e          state_q, state_n;
    logic [CNT_W-1:0] eff, off, fill_a, fill_n;
    logic [IDX_W-1:0] get_a, get_n, put_n;
    logic             en, ack_ok, room, drop, lost_n, wm_ok;

    // Release and push datapath: acknowledge first, then the write.
    always_comb begin
        eff = (cfg_size > DEPTH_C) ? DEPTH_C : cfg_size;
        en  = (eff != '0);
        if ({1'b0, ack_idx} >= {1'b0, get_q}) begin
            off = {1'b0, ack_idx} - {1'b0, get_q};
        end else begin
            off = {1'b0, ack_idx} + eff - {1'b0, get_q};
        end
        ack_ok = en && ack_valid && ({1'b0, ack_idx} < eff) && (off < fill_q);
        fill_a = ack_ok ? (fill_q - off - ONE_C) : fill_q;
        get_a  = ack_ok ? wrap_inc(ack_idx, eff) : get_q;
        room   = (fill_a < eff);
        store  = en && wr_valid && (room || cfg_ovwr);
        drop   = en && wr_valid && !room && !cfg_ovwr;
        put_n  = store ? wrap_inc(put_q, eff) : put_q;
        get_n  = (store && !room) ? wrap_inc(get_a, eff) : get_a;
        fill_n = (store && room) ? (fill_a + ONE_C) : fill_a;
        lost_n = drop ? 1'b1 : (ack_ok ? 1'b0 : lost_q);
        if (!en) begin
            put_n  = '0;
            get_n  = '0;
            fill_n = '0;
            lost_n = 1'b0;
        end
        wm_ok  = (cfg_wmark != '0) && (cfg_wmark <= eff);
        events = '0;
        events[IRQ_NEW]   = store;
        events[IRQ_WMARK] = en && wm_ok && (fill_q < cfg_wmark) && (fill_n >= cfg_wmark);
        events[IRQ_FULL]  = en && (fill_n == eff) && (fill_q != eff);
        events[IRQ_LOST]  = drop;
    end

    // Next-state decision.
    always_comb begin
        if (!en) begin
            state_n = Q_OFF;
        end else if (fill_n == '0) begin
            state_n = Q_EMPTY;
        end else if (fill_n == eff) begin
            state_n = Q_FULL;
        end else begin
            state_n = Q_PARTIAL;
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= Q_OFF;
        end else begin
            state_q <= state_n;
        end
    end

    // Index, level and lost registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            put_q  <= '0;
            get_q  <= '0;
            fill_q <= '0;
            lost_q <= 1'b0;
        end else begin
            put_q  <= put_n;
            get_q  <= get_n;
            fill_q <= fill_n;
            lost_q <= lost_n;
        end
    end

    // State-decoded outputs.
    always_comb begin
        unique case (state_q)
            Q_OFF:     full_o = 1'b0;
            Q_EMPTY:   full_o = 1'b0;
            Q_PARTIAL: full_o = 1'b0;
            Q_FULL:    full_o = 1'b1;
            default:   full_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/rxq_irq.sv
module rxq_irq
    import rxq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IRQ_N-1:0] events,
    input  logic [IRQ_N-1:0] clr,
    output logic [IRQ_N-1:0] flags
);
    for (genvar i = 0; i < IRQ_N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flags[i] <= 1'b0;
            end else begin
                flags[i] <= events[i] | (flags[i] & ~clr[i]);
            end
        end
    end
endmodule

// File: rtl/rx_ack_queue.sv
module rx_ack_queue
    import rxq_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int REC_W = 32,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cfg_size,
    input  logic [CNT_W-1:0] cfg_wmark,
    input  logic             cfg_ovwr,
    input  logic             wr_valid,
    input  logic [REC_W-1:0] wr_data,
    input  logic             ack_valid,
    input  logic [IDX_W-1:0] ack_idx,
    input  logic [IRQ_N-1:0] irq_clr,
    output logic [REC_W-1:0] rd_data,
    output logic [CNT_W-1:0] fill_lvl,
    output logic [IDX_W-1:0] get_idx,
    output logic [IDX_W-1:0] put_idx,
    output logic             full,
    output logic             msg_lost,
    output logic [IRQ_N-1:0] irq
);
    logic             store;
    logic [IRQ_N-1:0] events;

    rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_size  (cfg_size),
        .cfg_wmark (cfg_wmark),
        .cfg_ovwr  (cfg_ovwr),
        .wr_valid  (wr_valid),
        .ack_valid (ack_valid),
        .ack_idx   (ack_idx),
        .store     (store),
        .put_q     (put_idx),
        .get_q     (get_idx),
        .fill_q    (fill_lvl),
        .lost_q    (msg_lost),
        .full_o    (full),
        .events    (events)
    );

    rxq_store #(.DEPTH(DEPTH), .REC_W(REC_W)) u_store (
        .clk   (clk),
        .we    (store),
        .waddr (put_idx),
        .wdata (wr_data),
        .raddr (get_idx),
        .rdata (rd_data)
    );

    rxq_irq u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .events (events),
        .clr    (irq_clr),
        .flags  (irq)
    );
endmodule

// File: rtl/rx_ack_queue_chk.sv
module rx_ack_queue_chk #(
    parameter int DEPTH = 64,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] cfg_size,
    input logic             cfg_ovwr,
    input logic             wr_valid,
    input logic             ack_valid,
    input logic [3:0]       irq_clr,
    input logic [CNT_W-1:0] fill_lvl,
    input logic [IDX_W-1:0] get_idx,
    input logic [IDX_W-1:0] put_idx,
    input logic             full,
    input logic             msg_lost,
    input logic [3:0]       irq
);
    // R2: a disabled queue is held empty
    a_r2_disabled_zero: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_size == '0 |=> fill_lvl == '0 && get_idx == '0 && put_idx == '0 && !full);

    // R6: blocking mode keeps a full queue unchanged and flags the loss
    a_r6_block_drop: assert property (@(posedge clk) disable iff (!rst_n)
        full && !cfg_ovwr && wr_valid && !ack_valid && cfg_size != '0
        |=> $stable(put_idx) && $stable(fill_lvl) && msg_lost && irq[3]);

    // R7: overwrite mode keeps the queue full
    a_r7_ovwr_stays_full: assert property (@(posedge clk) disable iff (!rst_n)
        full && cfg_ovwr && wr_valid && !ack_valid && cfg_size != '0
        |=> full && $stable(fill_lvl) && !$rose(irq[3]));

    // R3: no write and no acknowledge moves nothing
    a_r3_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_valid && !ack_valid && cfg_size != '0
        |=> $stable(fill_lvl) && $stable(get_idx) && $stable(put_idx));

    // R9: full status implies a nonzero level within the array
    a_r9_full_level: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> fill_lvl != '0 && fill_lvl <= CNT_W'(DEPTH));

    // R11: a write with room raises the new-message flag
    a_r11_new_flag: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !full && !ack_valid && cfg_size != '0 |=> irq[0]);

    // R12: clearing the watermark flag without a write leaves it low
    a_r12_clear_wmark: assert property (@(posedge clk) disable iff (!rst_n)
        irq_clr[1] && !wr_valid |=> !irq[1]);
endmodule

bind rx_ack_queue rx_ack_queue_chk #(.DEPTH(DEPTH)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_size  (cfg_size),
    .cfg_ovwr  (cfg_ovwr),
    .wr_valid  (wr_valid),
    .ack_valid (ack_valid),
    .irq_clr   (irq_clr),
    .fill_lvl  (fill_lvl),
    .get_idx   (get_idx),
    .put_idx   (put_idx),
    .full      (full),
    .msg_lost  (msg_lost),
    .irq       (irq)
);

// File: tb/test_rx_ack_queue.sv
`timescale 1ns/1ps
module test_rx_ack_queue;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  cfg_size = '0;
    logic [6:0]  cfg_wmark = '0;
    logic        cfg_ovwr = 1'b0;
    logic        wr_valid = 1'b0;
    logic [31:0] wr_data = '0;
    logic        ack_valid = 1'b0;
    logic [5:0]  ack_idx = '0;
    logic [3:0]  irq_clr = '0;
    logic [31:0] rd_data;
    logic [6:0]  fill_lvl;
    logic [5:0]  get_idx, put_idx;
    logic        full, msg_lost;
    logic [3:0]  irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    rx_ack_queue i_rx_ack_queue (
        .clk(clk), .rst_n(rst_n), .cfg_size(cfg_size), .cfg_wmark(cfg_wmark),
        .cfg_ovwr(cfg_ovwr), .wr_valid(wr_valid), .wr_data(wr_data),
        .ack_valid(ack_valid), .ack_idx(ack_idx), .irq_clr(irq_clr),
        .rd_data(rd_data), .fill_lvl(fill_lvl), .get_idx(get_idx),
        .put_idx(put_idx), .full(full), .msg_lost(msg_lost), .irq(irq)
    );

    // Behavioural reference model
    int          m_fill, m_get, m_put, m_es, m_f0, m_off, m_wm;
    bit          m_lost, m_ackok, m_st, m_dr;
    logic [3:0]  m_irq;
    logic [31:0] m_mem [64];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_fill = 0; m_get = 0; m_put = 0; m_lost = 0; m_irq = '0;
        end else begin
            m_es = (int'(cfg_size) > 64) ? 64 : int'(cfg_size);
            m_irq = m_irq & ~irq_clr;
            if (m_es == 0) begin
                m_fill = 0; m_get = 0; m_put = 0; m_lost = 0;
            end else begin
                m_f0 = m_fill; m_ackok = 0; m_st = 0; m_dr = 0;
                if (ack_valid && int'(ack_idx) < m_es) begin
                    m_off = (int'(ack_idx) - m_get + m_es) % m_es;
                    if (m_off < m_fill) begin
                        m_fill = m_fill - m_off - 1;
                        m_get = (int'(ack_idx) + 1) % m_es;
                        m_ackok = 1;
                    end
                end
                if (wr_valid) begin
                    if (m_fill < m_es) begin
                        m_mem[m_put] = wr_data; m_put = (m_put + 1) % m_es;
                        m_fill++; m_st = 1;
                    end else if (cfg_ovwr) begin
                        m_mem[m_put] = wr_data; m_put = (m_put + 1) % m_es;
                        m_get = (m_get + 1) % m_es; m_st = 1;
                    end else begin
                        m_dr = 1;
                    end
                end
                if (m_dr) m_lost = 1;
                else if (m_ackok) m_lost = 0;
                m_wm = int'(cfg_wmark);
                if (m_st) m_irq[0] = 1'b1;
                if (m_wm != 0 && m_wm <= m_es && m_f0 < m_wm && m_fill >= m_wm) m_irq[1] = 1'b1;
                if (m_fill == m_es && m_f0 != m_es) m_irq[2] = 1'b1;
                if (m_dr) m_irq[3] = 1'b1;
            end
        end
    end

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R3 fill level", fill_lvl, m_fill);
            chk("R4 get index", get_idx, m_get);
            chk("R3 put index", put_idx, m_put);
            chk("R9 full flag", full, (m_es != 0 && m_fill == m_es));
            chk("R8 lost status", msg_lost, m_lost);
            chk("R12 irq flags", irq, m_irq);
            if (m_fill > 0) chk("R3 read data", rd_data, m_mem[m_get]);
        end
    end

    task automatic op(input bit wv, input logic [31:0] wd, input bit av,
                      input logic [5:0] ai, input logic [3:0] cl);
        wr_valid = wv; wr_data = wd; ack_valid = av; ack_idx = ai; irq_clr = cl;
        @(posedge clk);
        @(negedge clk);
        #1;
        wr_valid = 0; ack_valid = 0; irq_clr = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int lf;
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk); #1;
        // R1 reset state
        chk("R1 reset fill", fill_lvl, 0);
        chk("R1 reset irq", irq, 0);
        chk("R1 reset lost", msg_lost, 0);

        // R2 disabled queue ignores traffic
        op(1, 32'hDEAD0001, 1, 6'd0, '0);
        chk("R2 disabled fill", fill_lvl, 0);
        chk("R2 disabled irq", irq, 0);

        // size 4, watermark 3, blocking
        cfg_size = 7'd4; cfg_wmark = 7'd3; cfg_ovwr = 0;
        for (int i = 0; i < 4; i++) op(1, 32'hA000 + i, 0, '0, '0);
        chk("R9 full after four", full, 1);
        chk("R10 R11 irq after fill", irq, 4'b0111);
        op(0, '0, 0, '0, 4'hF);
        chk("R12 cleared", irq, 0);
        op(1, 32'hA004, 0, '0, '0);
        chk("R6 drop fill", fill_lvl, 4);
        chk("R6 drop lost", msg_lost, 1);
        chk("R6 drop irq", irq, 4'b1000);
        chk("R3 oldest record", rd_data, 32'hA000);
        op(0, '0, 1, 6'd1, 4'hF);
        chk("R4 ack fill", fill_lvl, 2);
        chk("R4 ack get", get_idx, 2);
        chk("R8 lost cleared", msg_lost, 0);
        op(0, '0, 1, 6'd1, '0);
        chk("R4 stale ack ignored", fill_lvl, 2);
        op(0, '0, 1, 6'd7, '0);
        chk("R4 out-of-range ack ignored", get_idx, 2);
        op(1, 32'hB000, 0, '0, '0);
        op(1, 32'hB001, 0, '0, '0);
        chk("R10 watermark again", irq[1], 1);
        op(1, 32'hC000, 1, 6'd2, 4'hF);
        chk("R5 same-cycle fill", fill_lvl, 4);
        chk("R5 same-cycle get", get_idx, 3);
        chk("R5 same-cycle lost", msg_lost, 0);
        cfg_ovwr = 1;
        op(1, 32'hD000, 0, '0, 4'hF);
        chk("R7 overwrite get", get_idx, 0);
        chk("R7 overwrite fill", fill_lvl, 4);
        chk("R7 overwrite no loss", irq[3], 0);
        chk("R7 oldest now", rd_data, 32'hB000);

        // Mixed traffic on size 5
        op(0, '0, 0, '0, 4'hF);
        cfg_size = 0; op(0, '0, 0, '0, '0);
        cfg_size = 7'd5; cfg_wmark = 7'd2;
        lf = 32'h1ACE;
        for (int c = 0; c < 3000; c++) begin
            lf = (lf >> 1) ^ ((lf & 1) ? 32'hB400 : 0);
            cfg_ovwr = (c / 300) % 2;
            op(lf[0] | lf[3], 32'(lf * 7 + c), lf[1] & lf[2],
               6'((m_get + lf[5:4]) % 5), 4'(lf[9:6] & {4{lf[10]}}));
        end

        // Full 64-element size with wraparound, watermark 0
        cfg_size = 0; op(0, '0, 0, '0, 4'hF);
        cfg_size = 7'd64; cfg_wmark = 7'd0; cfg_ovwr = 0;
        for (int i = 0; i < 64; i++) op(1, 32'hE000 + i, 0, '0, '0);
        chk("R9 full at 64", full, 1);
        chk("R10 watermark 0 disabled", irq[1], 0);
        op(0, '0, 1, 6'd63, '0);
        chk("R4 release all", fill_lvl, 0);
        chk("R4 wrap get", get_idx, 0);

        // Watermark above size is disabled
        cfg_size = 0; op(0, '0, 0, '0, 4'hF);
        cfg_size = 7'd7; cfg_wmark = 7'd9;
        for (int i = 0; i < 7; i++) op(1, 32'hF000 + i, 0, '0, '0);
        chk("R10 watermark over size", irq[1], 0);
        chk("R9 full irq size 7", irq[2], 1);
        cfg_size = 7'd100;
        op(0, '0, 0, '0, '0);
        chk("R2 clamp keeps fill", fill_lvl, 7);

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule